// File: doc/BRIEF.md
# IPv4 Fast-Path Header Rewriter

This block sits between a header parser and the forwarding fabric of a router line card. Each transfer gives it one 20-byte IPv4 header and the result of the route lookup for that header: a hit bit and an egress port. Per header it decides one of two things. The packet can stay on the fast path, where it leaves with a decremented TTL, an incrementally corrected header checksum and the looked-up port. Otherwise it goes to a slow-path processor, which handles the exception and any ICMP reply, and the block marks it with a reason code.

There is one registered pipeline stage with valid/ready flow control on both sides. A stalled output holds its contents, and every accepted header leaves exactly once. Exception classes are malformed version or length, options, fragments, multicast destinations, expiring TTL and route miss. When several apply at once, a fixed priority picks the one that is reported.

Top module: `ipfp_fastpath`

## Requirements
- R1: `in_hdr` carries header byte 0 in bits 159:152. The TTL byte sits in bits 95:88, the protocol in 87:80, the checksum in 79:64 and the destination address in 31:0. For a fast-path header, the output TTL equals the input TTL minus one.
- R2: For a fast-path header, the output checksum field is such that the one's-complement sum of all ten 16-bit words of the output header is 0xFFFF. Only the TTL/protocol word and the checksum word differ from the input.
- R3: An input TTL of 0 or 1 sends the header to the slow path with reason 5. TTL 2 and above is not an exception.
- R4: IHL (bits 155:152) above 5 sends the header to the slow path with reason 2 (options).
- R5: A fragment goes to the slow path with reason 3. A header is a fragment when the MF flag (bit 109) is set or the 13-bit fragment offset (bits 108:96) is nonzero.
- R6: A destination whose top four bits are 1110 (224.0.0.0/4) goes to the slow path with reason 4. Addresses 223.255.255.255 and 240.0.0.0 are not multicast.
- R7: A lookup miss (`in_hit` = 0) sends the header to the slow path with reason 6.
- R8: Version (bits 159:156) other than 4, or IHL below 5, sends the header to the slow path with reason 1 (malformed).
- R9: When several conditions hold, the reported reason follows this priority: malformed 1, options 2, fragment 3, multicast 4, TTL 5, miss 6.
- R10: A slow-path header leaves unmodified, with `out_slow` = 1 and `out_port` = 0. A fast-path header leaves with `out_slow` = 0, reason 0 and `out_port` equal to the input port.
- R11: `in_ready` is high whenever the output register is empty or being drained. A header accepted at one clock edge is presented at the outputs right after that edge.
- R12: While `out_valid` is high and `out_ready` low, all outputs hold their values. Each accepted header is presented exactly once, with no drop and no duplicate.
- R13: While `rst_n` is low, and right after it is released, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Header and lookup result are present |
| in_ready | output | 1 | Block can accept a header this cycle |
| in_hdr | input | 160 | IPv4 header, byte 0 in the top bits |
| in_hit | input | 1 | Route lookup hit |
| in_port | input | PORT_W (4) | Egress port from the lookup |
| out_valid | output | 1 | Output header is present |
| out_ready | input | 1 | Downstream accepts the output |
| out_hdr | output | 160 | Rewritten or untouched header |
| out_port | output | PORT_W (4) | Egress port, 0 on the slow path |
| out_slow | output | 1 | Header goes to the slow path |
| out_reason | output | 3 | Exception code, 0 on the fast path |

## Verification
The assertions assume that the input fields hold still only within a handshake. They assume nothing about their contents, so the classification properties hold for any header. The incremental checksum is correct only if the incoming checksum was already valid. For that reason every stimulus header carries a checksum computed over its own words, and the bench checks each fast-path result by recomputing the sum over the whole output header. The bench honours the handshake: it changes inputs only at the falling edge and keeps a header on the inputs until it has been accepted.

// File: rtl/ipfp_pkg.sv
package ipfp_pkg;

  localparam int HDR_BYTES = 20;
  localparam int HDR_W     = HDR_BYTES * 8;
  localparam int WORD_W    = 16;

  // field positions, byte 0 of the header in the top bits
  localparam int VER_LSB   = HDR_W - 4;
  localparam int IHL_LSB   = HDR_W - 8;
  localparam int MF_BIT    = HDR_W - 51;
  localparam int FOFF_LSB  = HDR_W - 64;
  localparam int TTL_LSB   = HDR_W - 72;
  localparam int PROTO_LSB = HDR_W - 80;
  localparam int CSUM_LSB  = HDR_W - 96;
  localparam int DST_LSB   = 0;

  localparam logic [3:0] IP_VERSION = 4'd4;
  localparam logic [3:0] MIN_IHL    = 4'd5;
  localparam logic [3:0] MCAST_TOP  = 4'hE;

  typedef enum logic [2:0] {
    RSN_NONE      = 3'd0,
    RSN_MALFORMED = 3'd1,
    RSN_OPTIONS   = 3'd2,
    RSN_FRAGMENT  = 3'd3,
    RSN_MCAST     = 3'd4,
    RSN_TTL       = 3'd5,
    RSN_NOROUTE   = 3'd6
  } reason_e;

  localparam int NUM_EXC = 6;

endpackage

// File: rtl/ipfp_classify.sv
module ipfp_classify
  import ipfp_pkg::*;
(
  input  logic [3:0]  version,
  input  logic [3:0]  ihl,
  input  logic        mf,
  input  logic [12:0] frag_off,
  input  logic [7:0]  ttl,
  input  logic [3:0]  dst_top,
  input  logic        hit,
  output reason_e     reason
);

  // exception flags, index 0 has the highest priority (R9)
  logic [NUM_EXC-1:0] exc;
  reason_e            code [NUM_EXC];

  always_comb begin
    exc[0] = (version != IP_VERSION) || (ihl < MIN_IHL);   // R8
    exc[1] = (ihl > MIN_IHL);                              // R4
    exc[2] = mf || (frag_off != 13'd0);                    // R5
    exc[3] = (dst_top == MCAST_TOP);                       // R6
    exc[4] = (ttl <= 8'd1);                                // R3
    exc[5] = !hit;                                         // R7
  end

  assign code[0] = RSN_MALFORMED;
  assign code[1] = RSN_OPTIONS;
  assign code[2] = RSN_FRAGMENT;
  assign code[3] = RSN_MCAST;
  assign code[4] = RSN_TTL;
  assign code[5] = RSN_NOROUTE;

  // scan from the lowest priority up so the highest priority wins
  always_comb begin
    reason = RSN_NONE;
    for (int i = NUM_EXC - 1; i >= 0; i--) begin
      if (exc[i]) reason = code[i];
    end
  end

endmodule

// File: rtl/ipfp_csum_update.sv
module ipfp_csum_update #(
  parameter int W = 16
) (
  input  logic [W-1:0] old_csum,
  input  logic [W-1:0] old_word,
  input  logic [W-1:0] new_word,
  output logic [W-1:0] new_csum
);

  logic [W+1:0] sum3;
  logic [W:0]   fold1;
  logic [W-1:0] fold2;

  // one's-complement: new = ~(~old_csum + ~old_word + new_word)
  always_comb begin
    sum3  = {2'b00, ~old_csum} + {2'b00, ~old_word} + {2'b00, new_word};
    fold1 = {1'b0, sum3[W-1:0]} + {{(W-1){1'b0}}, sum3[W+1:W]};
    fold2 = fold1[W-1:0] + {{(W-1){1'b0}}, fold1[W]};
    new_csum = ~fold2;
  end

  // a second end-around carry never remains
  always_comb begin
    if (fold1[W]) a_r2_fold_done: assert (fold1[W-1:0] <= W'(2));
  end

endmodule

// File: rtl/ipfp_rewrite.sv
module ipfp_rewrite
  import ipfp_pkg::*;
#(
  parameter int PORT_W = 4
) (
  input  logic [HDR_W-1:0]  hdr_in,
  input  logic              slow,
  input  logic [PORT_W-1:0] port_in,
  output logic [HDR_W-1:0]  hdr_out,
  output logic [PORT_W-1:0] port_out
);

  logic [7:0]        ttl_old;
  logic [7:0]        ttl_new;
  logic [WORD_W-1:0] word_old;
  logic [WORD_W-1:0] word_new;
  logic [WORD_W-1:0] csum_old;
  logic [WORD_W-1:0] csum_new;

  assign ttl_old  = hdr_in[TTL_LSB +: 8];
  assign ttl_new  = ttl_old - 8'd1;
  assign word_old = hdr_in[PROTO_LSB +: WORD_W];
  assign word_new = {ttl_new, hdr_in[PROTO_LSB +: 8]};
  assign csum_old = hdr_in[CSUM_LSB +: WORD_W];

  ipfp_csum_update #(.W(WORD_W)) u_csum (
    .old_csum (csum_old),
    .old_word (word_old),
    .new_word (word_new),
    .new_csum (csum_new)
  );

  always_comb begin
    hdr_out = hdr_in;
    if (!slow) begin
      hdr_out[TTL_LSB +: 8]       = ttl_new;   // R1
      hdr_out[CSUM_LSB +: WORD_W] = csum_new;  // R2
    end
  end

  assign port_out = slow ? '0 : port_in;       // R10

endmodule

// File: rtl/ipfp_out_stage.sv
module ipfp_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic         valid_q;
  logic         valid_d;
  logic         load_en;
  logic [W-1:0] data_q;

  assign in_ready = !valid_q || out_ready;   // R11
  assign load_en  = in_valid && in_ready;

  always_comb begin
    if (load_en)        valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
    else                valid_d = valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) data_q <= in_data;
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

  a_r12_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r11_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

  a_r12_no_dup: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

endmodule

// File: rtl/ipfp_fastpath.sv
module ipfp_fastpath
  import ipfp_pkg::*;
#(
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [159:0]      in_hdr,
  input  logic              in_hit,
  input  logic [PORT_W-1:0] in_port,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [159:0]      out_hdr,
  output logic [PORT_W-1:0] out_port,
  output logic              out_slow,
  output logic [2:0]        out_reason
);

  localparam int PAY_W = HDR_W + PORT_W + 1 + 3;

  reason_e           rsn;
  logic              slow;
  logic [HDR_W-1:0]  hdr_rw;
  logic [PORT_W-1:0] port_rw;
  logic [PAY_W-1:0]  pay_in;
  logic [PAY_W-1:0]  pay_out;

  ipfp_classify u_classify (
    .version  (in_hdr[VER_LSB +: 4]),
    .ihl      (in_hdr[IHL_LSB +: 4]),
    .mf       (in_hdr[MF_BIT]),
    .frag_off (in_hdr[FOFF_LSB +: 13]),
    .ttl      (in_hdr[TTL_LSB +: 8]),
    .dst_top  (in_hdr[DST_LSB + 28 +: 4]),
    .hit      (in_hit),
    .reason   (rsn)
  );

  assign slow = (rsn != RSN_NONE);

  ipfp_rewrite #(.PORT_W(PORT_W)) u_rewrite (
    .hdr_in   (in_hdr),
    .slow     (slow),
    .port_in  (in_port),
    .hdr_out  (hdr_rw),
    .port_out (port_rw)
  );

  assign pay_in = {hdr_rw, port_rw, slow, rsn};

  ipfp_out_stage #(.W(PAY_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign {out_hdr, out_port, out_slow, out_reason} = pay_out;

  a_r1_ttl_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=>
      (out_slow || out_hdr[TTL_LSB +: 8] == $past(in_hdr[TTL_LSB +: 8]) - 8'd1));

  a_r3_ttl_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_hdr[TTL_LSB +: 8] <= 8'd1) |=> out_slow);

  a_r6_mcast_slow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_hdr[DST_LSB + 28 +: 4] == MCAST_TOP) |=> out_slow);

  a_r7_miss_slow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_hit) |=> out_slow);

  a_r10_slow_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=>
      (!out_slow || (out_hdr == $past(in_hdr) && out_port == '0)));

  a_r13_reset_empty: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

endmodule

// File: tb/test_ipfp_fastpath.sv
`timescale 1ns/1ps
module test_ipfp_fastpath;

  typedef struct packed {
    logic [3:0]  ver;
    logic [3:0]  ihl;
    logic        mf;
    logic [12:0] foff;
    logic [7:0]  ttl;
    logic [31:0] dst;
    logic        hit;
    logic [3:0]  port;
    logic [2:0]  rsn;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{4'd4, 4'd5, 1'b0, 13'd0,  8'd64,  32'h0A000001, 1'b1, 4'd3,  3'd0}, // R1 R2 R10
    '{4'd4, 4'd5, 1'b0, 13'd0,  8'd2,   32'hC0A80001, 1'b1, 4'd7,  3'd0}, // R3 boundary
    '{4'd4, 4'd5, 1'b0, 13'd0,  8'd1,   32'h0A000002, 1'b1, 4'd1,  3'd5}, // R3
    '{4'd4, 4'd5, 1'b0, 13'd0,  8'd0,   32'h0A000003, 1'b1, 4'd2,  3'd5}, // R3
    '{4'd4, 4'd6, 1'b0, 13'd0,  8'd64,  32'h0A000004, 1'b1, 4'd2,  3'd2}, // R4
    '{4'd4, 4'd15,1'b0, 13'd0,  8'd64,  32'h0A000004, 1'b1, 4'd2,  3'd2}, // R4
    '{4'd4, 4'd5, 1'b1, 13'd0,  8'd64,  32'h0A000005, 1'b1, 4'd4,  3'd3}, // R5 MF
    '{4'd4, 4'd5, 1'b0, 13'd5,  8'd64,  32'h0A000006, 1'b1, 4'd4,  3'd3}, // R5 offset
    '{4'd4, 4'd5, 1'b0, 13'd0,  8'd64,  32'hE0000001, 1'b1, 4'd5,  3'd4}, // R6
    '{4'd4, 4'd5, 1'b0, 13'd0,  8'd64,  32'hEFFFFFFF, 1'b1, 4'd5,  3'd4}, // R6
    '{4'd4, 4'd5, 1'b0, 13'd0,  8'd64,  32'hDFFFFFFF, 1'b1, 4'd6,  3'd0}, // R6 boundary
    '{4'd4, 4'd5, 1'b0, 13'd0,  8'd64,  32'hF0000000, 1'b1, 4'd6,  3'd0}, // R6 boundary
    '{4'd4, 4'd5, 1'b0, 13'd0,  8'd64,  32'h0A000007, 1'b0, 4'd9,  3'd6}, // R7
    '{4'd6, 4'd5, 1'b0, 13'd0,  8'd64,  32'h0A000008, 1'b1, 4'd9,  3'd1}, // R8 version
    '{4'd4, 4'd4, 1'b0, 13'd0,  8'd64,  32'h0A000009, 1'b1, 4'd9,  3'd1}, // R8 IHL
    '{4'd5, 4'd7, 1'b1, 13'd1,  8'd0,   32'hE0000002, 1'b0, 4'd9,  3'd1}, // R9
    '{4'd4, 4'd6, 1'b1, 13'd0,  8'd1,   32'hE0000003, 1'b0, 4'd9,  3'd2}, // R9
    '{4'd4, 4'd5, 1'b1, 13'd0,  8'd0,   32'hE0000004, 1'b0, 4'd9,  3'd3}, // R9
    '{4'd4, 4'd5, 1'b0, 13'd0,  8'd1,   32'hE0000005, 1'b0, 4'd9,  3'd4}, // R9
    '{4'd4, 4'd5, 1'b0, 13'd0,  8'd255, 32'hFFFF0000 ^ 32'h1F000000, 1'b0, 4'd15, 3'd4}  // R9 then R7 below
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [159:0] in_hdr;
  logic         in_hit;
  logic [3:0]   in_port;
  logic         out_valid;
  logic         out_ready;
  logic [159:0] out_hdr;
  logic [3:0]   out_port;
  logic         out_slow;
  logic [2:0]   out_reason;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  ipfp_fastpath #(.PORT_W(4)) i_ipfp_fastpath (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_hdr(in_hdr), .in_hit(in_hit), .in_port(in_port),
    .out_valid(out_valid), .out_ready(out_ready), .out_hdr(out_hdr),
    .out_port(out_port), .out_slow(out_slow), .out_reason(out_reason)
  );

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 20000", cycles);
      finish_run();
    end
  end

  task automatic chk(string req, logic [159:0] act, logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ones_sum(logic [159:0] h);
    logic [31:0] s = 32'd0;
    for (int i = 0; i < 10; i++) s += {16'd0, h[i*16 +: 16]};
    s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
    s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
    return s[15:0];
  endfunction

  function automatic logic [159:0] with_csum(logic [159:0] h);
    logic [159:0] r = h;
    r[79:64] = 16'h0000;
    r[79:64] = ~ones_sum(r);
    return r;
  endfunction

  function automatic logic [159:0] build(vec_t v, int idx);
    logic [159:0] h;
    h = {v.ver, v.ihl, 8'h00, 16'd20, 16'(idx * 16'h0357 + 16'h1234),
         1'b0, 1'b0, v.mf, v.foff, v.ttl, 8'(8'h06 + idx * 8'd5), 16'h0000,
         32'hAC10_0000 + 32'(idx * 32'h0001_0203), v.dst};
    return with_csum(h);
  endfunction

  function automatic string req_of(logic [2:0] r);
    case (r)
      3'd1: return "R8";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R3";
      3'd6: return "R7";
      default: return "R1";
    endcase
  endfunction

  // drive one header at the falling edge, then check it after the next rising edge
  task automatic send(logic [159:0] h, logic hit, logic [3:0] port);
    @(negedge clk);
    in_valid = 1'b1;
    in_hdr   = h;
    in_hit   = hit;
    in_port  = port;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_out(string req, logic [159:0] h, logic [3:0] port, logic [2:0] rsn);
    logic [159:0] exp_h;
    exp_h = h;
    if (rsn == 3'd0) begin
      exp_h[95:88] = h[95:88] - 8'd1;
      exp_h[79:64] = 16'h0000;
      exp_h[79:64] = ~ones_sum(exp_h);
    end
    chk({req, " valid"}, 160'(out_valid), 160'(1'b1));
    chk({req, " slow flag (R10)"}, 160'(out_slow), 160'(rsn != 3'd0));
    chk({req, " reason (R9)"}, 160'(out_reason), 160'(rsn));
    chk({req, " port (R10)"}, 160'(out_port), 160'((rsn == 3'd0) ? port : 4'd0));
    chk({req, " header (R1 R2 R10)"}, out_hdr, exp_h);
    if (rsn == 3'd0) chk("R2 checksum verifies", 160'(ones_sum(out_hdr)), 160'(16'hFFFF));
  endtask

  initial begin
    logic [159:0] ha;
    logic [159:0] hb;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_hdr    = '0;
    in_hit    = 1'b0;
    in_port   = '0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk("R13 empty in reset", 160'(out_valid), 160'(1'b0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 empty after reset", 160'(out_valid), 160'(1'b0));
    chk("R11 ready when empty", 160'(in_ready), 160'(1'b1));
    out_ready = 1'b1;

    // vector walk; the last entry also covers R7 under a multicast address
    for (int i = 0; i < NV; i++) begin
      ha = build(VECS[i], i);
      send(ha, VECS[i].hit, VECS[i].port);
      check_out(req_of(VECS[i].rsn), ha, VECS[i].port, VECS[i].rsn);
    end

    // R12: drained output does not repeat
    @(negedge clk);
    chk("R12 no duplicate", 160'(out_valid), 160'(1'b0));

    // R11 R12: backpressure
    ha = build(VECS[0], 40);
    hb = build(VECS[1], 41);
    out_ready = 1'b0;
    send(ha, 1'b1, 4'd11);
    in_valid = 1'b1;
    in_hdr   = hb;
    in_hit   = 1'b1;
    in_port  = 4'd12;
    chk("R11 not ready when full", 160'(in_ready), 160'(1'b0));
    repeat (3) @(negedge clk);
    check_out("R12 held", ha, 4'd11, 3'd0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out("R11 next after drain", hb, 4'd12, 3'd0);
    @(negedge clk);
    chk("R12 no duplicate after stall", 160'(out_valid), 160'(1'b0));

    // R13: reset while holding data
    out_ready = 1'b0;
    send(ha, 1'b1, 4'd1);
    rst_n = 1'b0;
    #1;
    chk("R13 reset clears valid", 160'(out_valid), 160'(1'b0));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 stays empty", 160'(out_valid), 160'(1'b0));

    finish_run();
  end

endmodule